// File: doc/BRIEF.md
# Hashed Position Table

This block remembers, for every value of a 12-bit hash of a 3-byte window, the input position where a window with that hash was last seen. A compressor front end presents one hash index per input byte. For each accepted index the block returns the position stored in that row and whether the row holds anything. In the same cycle it overwrites the row with the position of the current byte. A match checker downstream then compares the bytes at the two positions.

A position is stored as a coarse group counter plus a 2-bit phase. The counter advances once for every three accepted bytes. The phase gives the byte's place within its group of three. This way the downstream memory banks can be selected and addressed without any divide or modulo-by-three. Each row has its own valid bit, held in a register vector apart from the position storage, so a clear empties the whole table in a single cycle.

Top module: `offset_table`

## Requirements
- R1: After reset `rsp_vld_o` is low and the position counter is zero. The first accepted lookup reports `cur_off_o`=0 and `cur_tag_o`=0.
- R2: A lookup of a row not written since the last reset or clear reports `prev_valid_o`=0.
- R3: A lookup is accepted in a cycle where `en_i`=1, `idx_vld_i`=1 and `clear_i`=0. `rsp_vld_o` is high in exactly the cycle after each accepted lookup and low in every other cycle.
- R4: A lookup of a row that was written earlier reports `prev_valid_o`=1, with `prev_off_o`/`prev_tag_o` equal to the position written by the most recent earlier accepted lookup of that row.
- R5: Each accepted lookup reports its own position in `cur_off_o`/`cur_tag_o`, and that position is written into the row. The phase runs 0, 1, 2, 0, … across accepted lookups. The group counter increases by one after phase 2 and wraps modulo 2^19.
- R6: Read and write of the same row in one cycle returns the old contents. Two back-to-back lookups of one row make the second return the position of the first.
- R7: `clear_i` in one cycle invalidates all 4096 rows and resets the counter to group 0, phase 0. A lookup presented together with `clear_i` is ignored: no response and no write.
- R8: While `en_i`=0 no lookup is accepted, even with `idx_vld_i`=1. The counter holds, no row is written and no response is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Empty the table and restart the position count |
| en_i | input | 1 | Enable; low stalls the block |
| idx_vld_i | input | 1 | A hash index is presented |
| idx_i | input | 12 | Hash index (row address) |
| rsp_vld_o | output | 1 | Response for the lookup of the previous cycle |
| prev_valid_o | output | 1 | The row held a stored position |
| prev_off_o | output | 19 | Stored group counter |
| prev_tag_o | output | 2 | Stored phase |
| cur_off_o | output | 19 | Group counter of the looked-up byte |
| cur_tag_o | output | 2 | Phase of the looked-up byte |

## Verification
A stale valid bit shows up on the very next lookup of that row as a wrong `prev_valid_o`. This is most visible right after a clear, when every lookup has to report an empty row. A counter that slips or stalls wrongly shows on the following response in `cur_off_o`/`cur_tag_o`. It shows again, much later, as a wrong position returned by the row that was written. A write-ordering fault, such as a forwarded new value or a write while disabled, changes `prev_*` on the next lookup of the affected row. Back-to-back lookups of one row and lookups after disabled cycles therefore expose it within one or two cycles.

// File: rtl/offset_table_pkg.sv
package offset_table_pkg;
    localparam int OT_IDX_W  = 12;
    localparam int OT_OFF_W  = 19;
    localparam int OT_TAG_W  = 2;
    localparam int OT_PHASES = 3;
endpackage

// File: rtl/ot_pos_counter.sv
module ot_pos_counter #(
    parameter int OFF_W  = offset_table_pkg::OT_OFF_W,
    parameter int TAG_W  = offset_table_pkg::OT_TAG_W,
    parameter int PHASES = offset_table_pkg::OT_PHASES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [OFF_W-1:0] off_o,
    output logic [TAG_W-1:0] tag_o
);
    localparam logic [TAG_W-1:0] LAST_TAG = TAG_W'(PHASES - 1);

    typedef struct packed {
        logic [OFF_W-1:0] off;
        logic [TAG_W-1:0] tag;
    } pos_t;

    pos_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else if (step_i) begin
            if (st_q.tag == LAST_TAG) begin
                st_d.tag = '0;
                st_d.off = st_q.off + 1'b1;
            end else begin
                st_d.tag = st_q.tag + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign off_o = st_q.off;
    assign tag_o = st_q.tag;
endmodule

// File: rtl/ot_valid_vec.sv
module ot_valid_vec #(
    parameter int IDX_W = offset_table_pkg::OT_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             op_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             old_bit_o
);
    localparam int ROWS = 1 << IDX_W;

    typedef struct packed {
        logic [ROWS-1:0] vec;
        logic            rd;
    } vst_t;

    vst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.vec = '0;
            st_d.rd  = 1'b0;
        end else if (op_i) begin
            st_d.rd         = st_q.vec[idx_i];
            st_d.vec[idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign old_bit_o = st_q.rd;
endmodule

// File: rtl/ot_row_ram.sv
module ot_row_ram #(
    parameter int IDX_W  = offset_table_pkg::OT_IDX_W,
    parameter int DATA_W = offset_table_pkg::OT_OFF_W + offset_table_pkg::OT_TAG_W
) (
    input  logic              clk,
    input  logic              op_i,
    input  logic [IDX_W-1:0]  addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int ROWS = 1 << IDX_W;

    logic [DATA_W-1:0] mem [ROWS];
    logic [DATA_W-1:0] rdata_q;

    // Read and write share one edge; the nonblocking read returns the old row.
    always_ff @(posedge clk) begin
        if (op_i) begin
            rdata_q      <= mem[addr_i];
            mem[addr_i]  <= wdata_i;
        end
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/offset_table.sv
module offset_table
    import offset_table_pkg::*;
#(
    parameter int IDX_W  = OT_IDX_W,
    parameter int OFF_W  = OT_OFF_W,
    parameter int TAG_W  = OT_TAG_W,
    parameter int PHASES = OT_PHASES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             en_i,
    input  logic             idx_vld_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             rsp_vld_o,
    output logic             prev_valid_o,
    output logic [OFF_W-1:0] prev_off_o,
    output logic [TAG_W-1:0] prev_tag_o,
    output logic [OFF_W-1:0] cur_off_o,
    output logic [TAG_W-1:0] cur_tag_o
);
    localparam int DATA_W = OFF_W + TAG_W;

    typedef struct packed {
        logic             vld;
        logic [OFF_W-1:0] off;
        logic [TAG_W-1:0] tag;
    } rsp_t;

    logic             op;
    logic [OFF_W-1:0] pos_off;
    logic [TAG_W-1:0] pos_tag;
    logic [DATA_W-1:0] rdata;
    logic             old_bit;
    rsp_t             rsp_d, rsp_q;

    assign op = en_i && idx_vld_i && !clear_i;

    ot_pos_counter #(.OFF_W(OFF_W), .TAG_W(TAG_W), .PHASES(PHASES)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .step_i(op),
        .off_o(pos_off), .tag_o(pos_tag)
    );

    ot_valid_vec #(.IDX_W(IDX_W)) u_vld (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .op_i(op),
        .idx_i(idx_i), .old_bit_o(old_bit)
    );

    ot_row_ram #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_ram (
        .clk(clk), .op_i(op), .addr_i(idx_i),
        .wdata_i({pos_off, pos_tag}), .rdata_o(rdata)
    );

    always_comb begin
        rsp_d     = rsp_q;
        rsp_d.vld = op;
        if (op) begin
            rsp_d.off = pos_off;
            rsp_d.tag = pos_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_vld_o    = rsp_q.vld;
    assign cur_off_o    = rsp_q.off;
    assign cur_tag_o    = rsp_q.tag;
    assign prev_valid_o = old_bit;
    assign prev_off_o   = rdata[DATA_W-1:TAG_W];
    assign prev_tag_o   = rdata[TAG_W-1:0];
endmodule

// File: rtl/offset_table_chk.sv
module ot_checker #(
    parameter int OFF_W  = offset_table_pkg::OT_OFF_W,
    parameter int TAG_W  = offset_table_pkg::OT_TAG_W,
    parameter int PHASES = offset_table_pkg::OT_PHASES
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear_i,
    input logic             en_i,
    input logic             idx_vld_i,
    input logic             rsp_vld_o,
    input logic             prev_valid_o,
    input logic [OFF_W-1:0] cur_off_o,
    input logic [TAG_W-1:0] cur_tag_o
);
    localparam logic [TAG_W-1:0] LAST_TAG = TAG_W'(PHASES - 1);

    logic acc;
    logic fresh_q;
    assign acc = en_i && idx_vld_i && !clear_i;

    // High while no lookup has been accepted since reset or clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       fresh_q <= 1'b1;
        else if (clear_i) fresh_q <= 1'b1;
        else if (acc)     fresh_q <= 1'b0;
    end

    assert_rsp_after_lookup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_vld_o);

    assert_no_rsp_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !rsp_vld_o);

    assert_clear_drops_lookup_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !rsp_vld_o);

    assert_fresh_row_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && fresh_q) |=> !prev_valid_o);

    assert_fresh_pos_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && fresh_q) |=> (cur_off_o == '0 && cur_tag_o == '0));

    assert_tag_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld_o |-> (cur_tag_o <= LAST_TAG));

    assert_pos_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld_o && $past(rsp_vld_o)) |->
        (($past(cur_tag_o) == LAST_TAG)
            ? (cur_tag_o == '0 && cur_off_o == OFF_W'($past(cur_off_o) + 1'b1))
            : (cur_tag_o == TAG_W'($past(cur_tag_o) + 1'b1) && cur_off_o == $past(cur_off_o))));
endmodule

bind offset_table ot_checker #(.OFF_W(OFF_W), .TAG_W(TAG_W), .PHASES(PHASES)) u_chk (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .en_i(en_i), .idx_vld_i(idx_vld_i),
    .rsp_vld_o(rsp_vld_o), .prev_valid_o(prev_valid_o),
    .cur_off_o(cur_off_o), .cur_tag_o(cur_tag_o)
);

// File: tb/offset_table_test.sv
`timescale 1ns/1ps
module offset_table_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_i = 1'b0, en_i = 1'b0, idx_vld_i = 1'b0;
    logic [11:0] idx_i = '0;
    logic        rsp_vld_o, prev_valid_o;
    logic [18:0] prev_off_o, cur_off_o;
    logic [1:0]  prev_tag_o, cur_tag_o;

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model
    int  m_off[int];
    int  m_tag[int];
    int  c_off = 0, c_tag = 0;
    bit  e_rsp = 0, e_pv = 0;
    int  e_poff = 0, e_ptag = 0, e_coff = 0, e_ctag = 0;

    always #5 clk = ~clk;

    offset_table uut (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .en_i(en_i), .idx_vld_i(idx_vld_i),
        .idx_i(idx_i), .rsp_vld_o(rsp_vld_o), .prev_valid_o(prev_valid_o),
        .prev_off_o(prev_off_o), .prev_tag_o(prev_tag_o),
        .cur_off_o(cur_off_o), .cur_tag_o(cur_tag_o)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // drive at negedge, model at posedge, compare at the following negedge
    task automatic cyc(string req, bit en, bit vld, bit clr, int idx);
        en_i = en; idx_vld_i = vld; clear_i = clr; idx_i = 12'(idx);
        @(posedge clk);
        if (clr) begin
            m_off.delete(); m_tag.delete();
            c_off = 0; c_tag = 0; e_rsp = 0;
        end else if (en && vld) begin
            e_rsp  = 1;
            e_pv   = m_off.exists(idx);
            e_poff = e_pv ? m_off[idx] : 0;
            e_ptag = e_pv ? m_tag[idx] : 0;
            e_coff = c_off; e_ctag = c_tag;
            m_off[idx] = c_off; m_tag[idx] = c_tag;
            if (c_tag == 2) begin c_tag = 0; c_off = (c_off + 1) % (1 << 19); end
            else c_tag++;
        end else begin
            e_rsp = 0;
        end
        @(negedge clk);
        chk(req, "rsp_vld", int'(rsp_vld_o), int'(e_rsp));
        if (e_rsp) begin
            chk(req, "prev_valid", int'(prev_valid_o), int'(e_pv));
            if (e_pv) begin
                chk(req, "prev_off", int'(prev_off_o), e_poff);
                chk(req, "prev_tag", int'(prev_tag_o), e_ptag);
            end
            chk(req, "cur_off", int'(cur_off_o), e_coff);
            chk(req, "cur_tag", int'(cur_tag_o), e_ctag);
        end
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "rsp after reset", int'(rsp_vld_o), 0);
        cyc("R1", 1, 1, 0, 5);               // first position 0/0, row empty
        cyc("R2", 1, 1, 0, 0);
        cyc("R2", 1, 1, 0, 4095);
        for (int i = 0; i < 8; i++) cyc("R5", 1, 1, 0, 10 + i);
        cyc("R4", 1, 1, 0, 5);               // stored 0/0
        cyc("R4", 1, 1, 0, 4095);
        cyc("R6", 1, 1, 0, 100);
        cyc("R6", 1, 1, 0, 100);             // returns the previous cycle's position
        cyc("R6", 1, 1, 0, 100);
        cyc("R3", 0, 0, 0, 0);
        cyc("R3", 1, 0, 0, 7);
        for (int i = 0; i < 4; i++) cyc("R8", 0, 1, 0, 200);
        cyc("R8", 1, 1, 0, 200);             // not written while disabled, counter held
        cyc("R8", 1, 1, 0, 201);
        cyc("R7", 1, 1, 1, 5);               // clear with a lookup: dropped
        cyc("R7", 1, 1, 0, 5);               // empty again, position 0/0
        cyc("R7", 1, 1, 0, 100);
        cyc("R7", 1, 1, 0, 4095);
        cyc("R7", 1, 1, 0, 5);
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom % 100;
            int ix = (r < 5) ? 4095 : ((r < 10) ? 0 : ($urandom % 48));
            cyc("R4", (r % 7) != 0, (r % 5) != 0, r == 99, ix);
        end
        for (int i = 0; i < 6; i++) cyc("R5", 1, 1, 0, 3000 + i);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule